// File: doc/BRIEF.md
# Raster Line Event Scheduler

This block tracks where a video host is in its frame without reading that position from the host. A dot clock drives it, and every eight dot clocks make one host bus cycle. The block counts bus cycles within a line and lines within a frame. The line length can be set to 63, 64 or 65 bus cycles. The line counter wraps at a parameterised number of lines per frame.

A controller programs a target line and a lead time of 0 to 7 bus cycles. The block raises a one-dot-clock event pulse, plus a sticky flag, that many bus cycles before the target line begins. This leaves the controller time to take the bus. The controller can reload the target after each event while the counters keep running.

A calibration mode measures how many bus cycles lie between two successive rising edges of an external line-start reference. The controller uses this count to find out which line length the host uses. The reference input is taken as already synchronous to the dot clock.

Top module: `raster_event_sched`

## Requirements
- R1: While reset is asserted, and right after it, cur_line, cur_cycle, evt_pulse, evt_flag, cal_done and cal_count are all zero.
- R2: cur_cycle advances by one once every DOTS_PER_CYC (default 8) dot clocks.
- R3: The line length is set by len_sel: 2'b00 gives 63, 2'b01 gives 64, and 2'b10 or 2'b11 gives 65. cur_cycle runs from 0 to length-1, then returns to 0 while cur_line advances by one.
- R4: cur_line returns to 0 after LINES-1.
- R5: evt_pulse is high for exactly one dot clock. That dot clock is the first one of the bus cycle that lies `lead` bus cycles before the target line starts. For lead 1..7 this is line target-1 (wrapping from 0 to LINES-1) at cycle length-lead. For lead 0 it is cycle 0 of the target line.
- R6: While the configuration stays the same, evt_pulse repeats exactly once per frame, every LINES*length*DOTS_PER_CYC dot clocks.
- R7: A target written with tgt_wr while the block runs is used for the next match, including a match later in the same frame.
- R8: evt_flag is set by each event and stays set until evt_clr. If evt_clr and an event fall on the same clock, the flag stays set.
- R9: After cal_start, cal_count receives the number of bus cycles between the next two rising edges of line_ref, and cal_done rises. cal_done stays low until the second edge.
- R10: cal_start clears cal_done on the next clock and restarts the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_sel | input | 2 | Line length select (63/64/65) |
| lead | input | LEAD_W | Lead time in bus cycles |
| tgt_wr | input | 1 | Load strobe for the target line |
| tgt_line | input | LW | Target line number |
| evt_clr | input | 1 | Clears the sticky event flag |
| cal_start | input | 1 | Starts a calibration measurement |
| line_ref | input | 1 | External line-start reference |
| cur_line | output | LW | Current line count |
| cur_cycle | output | 7 | Current bus cycle within the line |
| evt_pulse | output | 1 | One-clock early-warning pulse |
| evt_flag | output | 1 | Sticky event flag |
| cal_done | output | 1 | Calibration result valid |
| cal_count | output | CAL_W | Measured bus cycles per line |

## Verification
The hardest case to reach is an event whose lead window crosses the frame boundary. Here the target is line 0, so the match has to happen on the last line of the previous frame. A second hard case is a calibration whose reference edges arrive at an arbitrary phase within a bus cycle. The bench shrinks the frame to eight lines so that whole frames pass quickly. It walks a table of length, lead and target settings that includes target 0 and lead 0. It checks the position and timing of each pulse, when the line advances, and the spacing between pulses. For calibration it sends reference edges exactly 63, 64 and 65 bus cycles apart, each starting at a different dot-clock offset.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int CW = 7;

  function automatic logic [CW-1:0] line_len(input logic [1:0] sel);
    case (sel)
      2'b00:   line_len = CW'(63);
      2'b01:   line_len = CW'(64);
      default: line_len = CW'(65);
    endcase
  endfunction

  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_ARM  = 2'd1,
    CAL_MEAS = 2'd2
  } cal_state_t;
endpackage

// File: rtl/raster_timebase.sv
module raster_timebase
  import raster_pkg::*;
#(
  parameter int DOTS_PER_CYC = 8,
  parameter int LINES        = 312,
  localparam int PW          = (DOTS_PER_CYC > 1) ? $clog2(DOTS_PER_CYC) : 1,
  localparam int LW          = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    len_sel,
  output logic          tick,
  output logic [CW-1:0] cyc_q,
  output logic [LW-1:0] line_q,
  output logic [CW-1:0] cyc_nx,
  output logic [LW-1:0] line_nx
);
  logic [PW-1:0] ph_q, ph_d;
  logic [CW-1:0] last_cyc;

  assign last_cyc = line_len(len_sel) - CW'(1);
  assign tick     = (ph_q == PW'(DOTS_PER_CYC - 1));

  always_comb begin
    ph_d    = tick ? '0 : ph_q + PW'(1);
    cyc_nx  = cyc_q;
    line_nx = line_q;
    if (tick) begin
      if (cyc_q >= last_cyc) begin
        cyc_nx  = '0;
        line_nx = (line_q >= LW'(LINES - 1)) ? '0 : line_q + LW'(1);
      end else begin
        cyc_nx = cyc_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      cyc_q  <= '0;
      line_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (tick) begin
        cyc_q  <= cyc_nx;
        line_q <= line_nx;
      end
    end
  end

  // R3: the cycle count returns to zero once the line end is reached
  assert_cyc_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cyc_q >= last_cyc) |=> (cyc_q == '0));

  // R4: the line count never passes the last line of the frame
  assert_line_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= LW'(LINES - 1));

  // R2: the cycle count only moves on a bus tick
  assert_cyc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cyc_q));
endmodule

// File: rtl/raster_match.sv
module raster_match
  import raster_pkg::*;
#(
  parameter int LINES  = 312,
  parameter int LEAD_W = 3,
  localparam int LW    = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CW-1:0]     cyc_nx,
  input  logic [LW-1:0]     line_nx,
  input  logic [1:0]        len_sel,
  input  logic [LEAD_W-1:0] lead,
  input  logic              tgt_wr,
  input  logic [LW-1:0]     tgt_in,
  input  logic              evt_clr,
  output logic              evt_pulse,
  output logic              evt_flag
);
  logic [LW-1:0] tgt_q, prev_line;
  logic [CW-1:0] hit_cyc;
  logic          hit, pulse_d, flag_d;

  assign prev_line = (tgt_q == '0) ? LW'(LINES - 1) : tgt_q - LW'(1);
  assign hit_cyc   = line_len(len_sel) - CW'(lead);

  always_comb begin
    if (lead == '0) hit = (cyc_nx == '0) && (line_nx == tgt_q);
    else            hit = (cyc_nx == hit_cyc) && (line_nx == prev_line);
    pulse_d = tick && hit;
    flag_d  = pulse_d || (evt_flag && !evt_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q     <= '0;
      evt_pulse <= 1'b0;
      evt_flag  <= 1'b0;
    end else begin
      if (tgt_wr) tgt_q <= tgt_in;
      evt_pulse <= pulse_d;
      evt_flag  <= flag_d;
    end
  end

  // R5: the event pulse lasts a single dot clock
  assert_pulse_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> !evt_pulse);

  // R8: the sticky flag is set whenever the pulse is
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> evt_flag);

  // R8: after a clear the flag follows only a coincident event
  assert_flag_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clr |=> (evt_flag == evt_pulse));
endmodule

// File: rtl/raster_calib.sv
module raster_calib
  import raster_pkg::*;
#(
  parameter int CAL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             line_ref,
  input  logic             cal_start,
  output logic [CAL_W-1:0] cal_count,
  output logic             cal_done
);
  cal_state_t       st_q, st_d;
  logic             ref_q, rise;
  logic [CAL_W-1:0] cnt_q, cnt_d, cnt_inc, res_d;
  logic             done_d;

  assign rise    = line_ref && !ref_q;
  assign cnt_inc = (tick && cnt_q != '1) ? cnt_q + CAL_W'(1) : cnt_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    res_d  = cal_count;
    done_d = cal_done;
    if (cal_start) begin
      st_d   = CAL_ARM;
      cnt_d  = '0;
      done_d = 1'b0;
    end else begin
      case (st_q)
        CAL_ARM: if (rise) begin
          st_d  = CAL_MEAS;
          cnt_d = '0;
        end
        CAL_MEAS: begin
          cnt_d = cnt_inc;
          if (rise) begin
            res_d  = cnt_inc;
            done_d = 1'b1;
            st_d   = CAL_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= CAL_IDLE;
      ref_q     <= 1'b0;
      cnt_q     <= '0;
      cal_count <= '0;
      cal_done  <= 1'b0;
    end else begin
      st_q      <= st_d;
      ref_q     <= line_ref;
      cnt_q     <= cnt_d;
      cal_count <= res_d;
      cal_done  <= done_d;
    end
  end

  // R10: a start request drops the done flag
  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_done);

  // R9: done only rises on a reference rising edge
  assert_done_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done) |-> $past(line_ref && !ref_q));
endmodule

// File: rtl/raster_event_sched.sv
module raster_event_sched
  import raster_pkg::*;
#(
  parameter int DOTS_PER_CYC = 8,
  parameter int LINES        = 312,
  parameter int LEAD_W       = 3,
  parameter int CAL_W        = 8,
  localparam int LW          = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        len_sel,
  input  logic [LEAD_W-1:0] lead,
  input  logic              tgt_wr,
  input  logic [LW-1:0]     tgt_line,
  input  logic              evt_clr,
  input  logic              cal_start,
  input  logic              line_ref,
  output logic [LW-1:0]     cur_line,
  output logic [CW-1:0]     cur_cycle,
  output logic              evt_pulse,
  output logic              evt_flag,
  output logic              cal_done,
  output logic [CAL_W-1:0]  cal_count
);
  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic          tick;
  logic [CW-1:0] cyc_nx;
  logic [LW-1:0] line_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  raster_timebase #(.DOTS_PER_CYC(DOTS_PER_CYC), .LINES(LINES)) u_tb (
    .clk(clk), .rst_n(rst_ni), .len_sel(len_sel), .tick(tick),
    .cyc_q(cur_cycle), .line_q(cur_line), .cyc_nx(cyc_nx), .line_nx(line_nx)
  );

  raster_match #(.LINES(LINES), .LEAD_W(LEAD_W)) u_match (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .cyc_nx(cyc_nx), .line_nx(line_nx),
    .len_sel(len_sel), .lead(lead), .tgt_wr(tgt_wr), .tgt_in(tgt_line),
    .evt_clr(evt_clr), .evt_pulse(evt_pulse), .evt_flag(evt_flag)
  );

  raster_calib #(.CAL_W(CAL_W)) u_cal (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .line_ref(line_ref),
    .cal_start(cal_start), .cal_count(cal_count), .cal_done(cal_done)
  );
endmodule

// File: tb/tb_raster_event_sched.sv
`timescale 1ns/1ps
module tb_raster_event_sched;
  localparam int LINES = 8;
  localparam int DOTS  = 8;
  localparam int LW    = $clog2(LINES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] len_sel = 2'b01;
  logic [2:0] lead = '0;
  logic tgt_wr = 1'b0;
  logic [LW-1:0] tgt_line = '0;
  logic evt_clr = 1'b0, cal_start = 1'b0, line_ref = 1'b0;
  logic [LW-1:0] cur_line;
  logic [6:0] cur_cycle;
  logic evt_pulse, evt_flag, cal_done;
  logic [7:0] cal_count;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  raster_event_sched #(.DOTS_PER_CYC(DOTS), .LINES(LINES)) dut (
    .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .lead(lead), .tgt_wr(tgt_wr),
    .tgt_line(tgt_line), .evt_clr(evt_clr), .cal_start(cal_start),
    .line_ref(line_ref), .cur_line(cur_line), .cur_cycle(cur_cycle),
    .evt_pulse(evt_pulse), .evt_flag(evt_flag), .cal_done(cal_done),
    .cal_count(cal_count)
  );

  // {len_sel[1:0], lead[2:0], target[2:0]}
  localparam logic [7:0] VEC [7] = '{
    {2'b00, 3'd4, 3'd3}, {2'b01, 3'd5, 3'd5}, {2'b10, 3'd4, 3'd2},
    {2'b01, 3'd0, 3'd6}, {2'b00, 3'd3, 3'd0}, {2'b11, 3'd7, 3'd1},
    {2'b01, 3'd1, 3'd7}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] s);
    return (s == 2'b00) ? 63 : (s == 2'b01) ? 64 : 65;
  endfunction

  task automatic wait_pulse(output int n);
    n = 0;
    while (!evt_pulse && n < 3 * LINES * 65 * DOTS) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic cal_run(input int ncyc, input int offs);
    @(negedge clk); cal_start = 1'b1;
    @(negedge clk); cal_start = 1'b0;
    check("R10 done cleared", int'(cal_done), 0);
    repeat (offs) @(negedge clk);
    line_ref = 1'b1;
    repeat (4) @(negedge clk);
    line_ref = 1'b0;
    repeat (ncyc * DOTS - 4) @(negedge clk);
    check("R9 done low before second edge", int'(cal_done), 0);
    line_ref = 1'b1;
    @(negedge clk);
    check("R9 done set", int'(cal_done), 1);
    check("R9 measured count", int'(cal_count), ncyc);
    repeat (3) @(negedge clk);
    line_ref = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, k, len, eline, ecyc;
    repeat (3) @(negedge clk);
    check("R1 line in reset", int'(cur_line), 0);
    check("R1 cycle in reset", int'(cur_cycle), 0);
    check("R1 pulse/flag in reset", int'({evt_pulse, evt_flag}), 0);
    check("R1 cal in reset", int'({cal_done, cal_count}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cycle after release", int'(cur_cycle), 0);

    // R2: spacing of cycle steps
    while (cur_cycle != 7'd1) @(negedge clk);
    n = 0;
    while (cur_cycle == 7'd1 && n < 100) begin @(negedge clk); n++; end
    check("R2 dots per bus cycle", n, DOTS);
    check("R2 cycle step", int'(cur_cycle), 2);

    // table walk: R3 R4 R5 R6 R8
    for (int i = 0; i < 7; i++) begin
      len = len_of(VEC[i][7:6]);
      eline = (VEC[i][5:3] == 0) ? int'(VEC[i][2:0])
            : ((VEC[i][2:0] == 0) ? LINES - 1 : int'(VEC[i][2:0]) - 1);
      ecyc = (VEC[i][5:3] == 0) ? 0 : len - int'(VEC[i][5:3]);
      @(negedge clk);
      len_sel = VEC[i][7:6]; lead = VEC[i][5:3]; tgt_line = VEC[i][2:0];
      tgt_wr = 1'b1; evt_clr = 1'b1;
      @(negedge clk);
      tgt_wr = 1'b0; evt_clr = 1'b0;
      wait_pulse(n);
      check("R5 pulse seen", int'(evt_pulse), 1);
      check("R5 pulse line", int'(cur_line), eline);
      check("R5 pulse cycle", int'(cur_cycle), ecyc);
      @(negedge clk);
      k = 1;
      check("R5 pulse width", int'(evt_pulse), 0);
      check("R8 flag set", int'(evt_flag), 1);
      if (VEC[i][5:3] != 0) begin
        while (int'(cur_line) == eline && k < 1000) begin @(negedge clk); k++; end
        check("R3 line advance delay", k, int'(VEC[i][5:3]) * DOTS);
        check("R3/R4 target line reached", int'(cur_line), int'(VEC[i][2:0]));
        check("R3 cycle wrapped", int'(cur_cycle), 0);
      end
      while (!evt_pulse && k < 3 * LINES * 65 * DOTS) begin @(negedge clk); k++; end
      check("R6 frame interval", k, LINES * len * DOTS);
    end

    // R7: reload target right after an event
    @(negedge clk);
    len_sel = 2'b01; lead = 3'd2; tgt_line = 3'd3; tgt_wr = 1'b1;
    @(negedge clk); tgt_wr = 1'b0;
    wait_pulse(n);
    tgt_line = 3'd5; tgt_wr = 1'b1;
    @(negedge clk); tgt_wr = 1'b0;
    k = 1;
    while (!evt_pulse && k < 5000) begin @(negedge clk); k++; end
    check("R7 reloaded target interval", k, 2 * 64 * DOTS);
    check("R7 reloaded line", int'(cur_line), 4);
    check("R7 reloaded cycle", int'(cur_cycle), 62);

    // R8: sticky hold and clear
    repeat (20) @(negedge clk);
    check("R8 flag held", int'(evt_flag), 1);
    evt_clr = 1'b1;
    @(negedge clk); evt_clr = 1'b0;
    check("R8 flag cleared", int'(evt_flag), 0);
    repeat (5) @(negedge clk);
    check("R8 flag stays clear", int'(evt_flag), 0);

    // R9 R10: calibration at different phases
    cal_run(63, 5);
    cal_run(64, 11);
    cal_run(65, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule